// File: doc/BRIEF.md
# Flash Completion Polling Sequencer

This is a host-side controller. It decides whether a flash program or erase operation, already started by other logic, has finished, and whether it ended well. A one-cycle `start` pulse arms the sequencer. The pulse carries the byte that was written and a choice of method. The sequencer then issues status reads to the flash through a simple request/response handshake and evaluates the status bits that come back. It reports the outcome as a one-cycle `done_pass` or `done_fail` pulse.

Two methods are available:
- **Data polling** compares status bit 7 with bit 7 of the expected byte.
- **Toggle polling** looks for bit 6 changing between two consecutive reads.

In both methods, status bit 5 is the device's timeout indication. It is never taken as a failure by itself. Once bit 5 is seen high, the sequencer reads again before it decides. A poll-round limit turns an endless poll into a failure.

Top module: `flash_poll_seq`

## Requirements
- R1: With `method`=0 (data polling), a returned byte whose bit 7 equals bit 7 of `exp_data` ends the poll with pass.
- R2: With `method`=0, a byte whose bit 7 differs and whose bit 5 is 0 causes another status read.
- R3: With `method`=0, a byte whose bit 7 differs and whose bit 5 is 1 causes exactly one further read. Bit 7 of that read decides: equal gives pass, different gives fail.
- R4: With `method`=1 (toggle polling), reads come in pairs. Equal bit 6 in the two reads of a pair gives pass.
- R5: With `method`=1, if bit 6 differs within a pair and bit 5 of the first read of the pair is 0, a new pair is started.
- R6: With `method`=1, if bit 6 differs within a pair and bit 5 of the first read of the pair is 1, two further reads follow. Equal bit 6 in them gives pass; a difference gives fail.
- R7: Only one read is outstanding at a time. `rd_req` is a one-cycle pulse, and the next one comes only after `rd_valid`. `done_pass` and `done_fail` are never high together. Each is a one-cycle pulse in the cycle after the deciding `rd_valid`.
- R8: A poll can start at most `MAX_POLLS` rounds. A round is one read in data polling and one pair in toggle polling. A round that would exceed the limit ends the poll with fail instead.
- R9: `start` while `busy` is high has no effect. `rd_valid` with no read outstanding has no effect.
- R10: After reset, `busy`, `rd_req`, `done_pass` and `done_fail` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a poll (taken only when idle) |
| method | input | 1 | 0 = data polling, 1 = toggle polling |
| exp_data | input | 8 | Byte that was programmed; bit 7 is used |
| rd_req | output | 1 | One-cycle request for a status read |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | 8 | Status byte returned |
| busy | output | 1 | Poll in progress |
| done_pass | output | 1 | One-cycle pulse: operation completed successfully |
| done_fail | output | 1 | One-cycle pulse: operation failed or limit reached |

## Verification
Data polling is tried with four response patterns:
- an immediate match, which exercises the single-read pass;
- a run of mismatches with bit 5 low, which shows the loop back;
- bit 5 high followed by a match;
- bit 5 high followed by a mismatch. These last two separate the recheck pass from the recheck fail.

Toggle polling is tried with:
- a stable first pair;
- a toggling pair with bit 5 low, followed by a stable pair;
- bit 5 high with a settled pair afterwards;
- bit 5 high with a still-toggling pair afterwards.

Endless mismatch and endless toggling are used to reach the round limit in each method. A second start during a long-latency read checks that the running poll keeps its own method and expected byte. A stray response while idle checks that no read or result follows it.

// File: rtl/flash_poll_seq.sv
module flash_poll_seq #(
  parameter int MAX_POLLS = 1000,
  localparam int CW = $clog2(MAX_POLLS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       method,
  input  logic [7:0] exp_data,
  output logic       rd_req,
  input  logic       rd_valid,
  input  logic [7:0] rd_data,
  output logic       busy,
  output logic       done_pass,
  output logic       done_fail
);
  typedef enum logic [2:0] {S_IDLE, S_D1, S_D2, S_T1, S_T2, S_T3, S_T4} st_t;

  st_t st;
  logic pend, exp7, keep6, keep5;
  logic [CW-1:0] rounds;

  assign busy   = (st != S_IDLE);
  assign rd_req = busy && !pend;

  wire evalv = pend && rd_valid;
  wire d7ok  = (rd_data[7] == exp7);
  wire tog   = (rd_data[6] != keep6);
  wire lim   = (rounds == CW'(MAX_POLLS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      pend <= 1'b0;
      exp7 <= 1'b0;
      keep6 <= 1'b0;
      keep5 <= 1'b0;
      rounds <= '0;
      done_pass <= 1'b0;
      done_fail <= 1'b0;
    end else begin
      done_pass <= 1'b0;
      done_fail <= 1'b0;
      if (rd_req) pend <= 1'b1;
      if (st == S_IDLE) begin
        if (start) begin
          exp7 <= exp_data[7];
          rounds <= CW'(1);
          pend <= 1'b0;
          st <= method ? S_T1 : S_D1;
        end
      end else if (evalv) begin
        pend <= 1'b0;
        case (st)
          S_D1:
            if (d7ok) begin
              st <= S_IDLE; done_pass <= 1'b1;
            end else if (rd_data[5]) begin
              st <= S_D2;
            end else if (lim) begin
              st <= S_IDLE; done_fail <= 1'b1;
            end else begin
              rounds <= rounds + 1'b1;
            end
          S_D2: begin
            st <= S_IDLE;
            done_pass <= d7ok;
            done_fail <= !d7ok;
          end
          S_T1: begin
            keep6 <= rd_data[6];
            keep5 <= rd_data[5];
            st <= S_T2;
          end
          S_T2:
            if (!tog) begin
              st <= S_IDLE; done_pass <= 1'b1;
            end else if (keep5) begin
              st <= S_T3;
            end else if (lim) begin
              st <= S_IDLE; done_fail <= 1'b1;
            end else begin
              rounds <= rounds + 1'b1;
              st <= S_T1;
            end
          S_T3: begin
            keep6 <= rd_data[6];
            st <= S_T4;
          end
          S_T4: begin
            st <= S_IDLE;
            done_pass <= !tog;
            done_fail <= tog;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_poll_seq_chk.sv
module flash_poll_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic rd_req,
  input logic rd_valid,
  input logic busy,
  input logic done_pass,
  input logic done_fail
);
  assert_req_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  assert_done_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_pass && done_fail));
  assert_pass_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_pass |=> !done_pass);
  assert_fail_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_fail |=> !done_fail);
  assert_done_after_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pass || done_fail) |-> $past(rd_valid));
  assert_idle_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req);
  assert_stay_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);
  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done_pass && !done_fail));
endmodule

bind flash_poll_seq flash_poll_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req),
  .rd_valid(rd_valid), .busy(busy), .done_pass(done_pass), .done_fail(done_fail)
);

// File: tb/tb_flash_poll_seq.sv
`timescale 1ns/1ps
module tb_flash_poll_seq;
  localparam int LIMIT = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, method = 1'b0, rd_valid = 1'b0;
  logic [7:0] exp_data = 8'h00, rd_data = 8'h00;
  logic rd_req, busy, done_pass, done_fail;

  int tests = 0, fails = 0, excl_bad = 0;
  logic [7:0] resp [16];

  always #4 clk = ~clk;

  flash_poll_seq #(.MAX_POLLS(LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .method(method), .exp_data(exp_data),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .done_pass(done_pass), .done_fail(done_fail));

  always @(negedge clk)
    if (rst_n && ((done_pass && done_fail) || (!busy && rd_req))) excl_bad++;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] rb(input int i);
    return resp[(i > 15) ? 15 : i];
  endfunction

  function automatic void model(input bit meth, input bit e7, output bit pass, output int n);
    int rnd = 1;
    logic [7:0] a, b;
    n = 0;
    forever begin
      if (!meth) begin
        a = rb(n); n++;
        if (a[7] == e7) begin pass = 1; return; end
        if (a[5]) begin a = rb(n); n++; pass = (a[7] == e7); return; end
      end else begin
        a = rb(n); b = rb(n + 1); n += 2;
        if (a[6] == b[6]) begin pass = 1; return; end
        if (a[5]) begin a = rb(n); b = rb(n + 1); n += 2; pass = (a[6] == b[6]); return; end
      end
      if (rnd == LIMIT) begin pass = 0; return; end
      rnd++;
    end
  endfunction

  task automatic run(input string req, input bit meth, input logic [7:0] expd, input int lat, input bit mid);
    bit epass, gotpass, got = 0, just = 0, reqbad = 0;
    int en, reads = 0, guard = 0;
    model(meth, expd[7], epass, en);
    @(negedge clk); start = 1; method = meth; exp_data = expd;
    @(negedge clk); start = 0;
    while (!got && guard < 5000) begin
      guard++;
      if (done_pass || done_fail) begin
        got = 1; gotpass = done_pass;
        chk(just, req, "result not in cycle after response", 0, 1);
      end else if (rd_req) begin
        reads++;
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          if (rd_req) reqbad = 1;
          if (mid && reads == 1 && k == 0) begin start = 1; method = ~meth; exp_data = ~expd; end
          if (k == 1) start = 0;
        end
        start = 0;
        rd_valid = 1; rd_data = rb(reads - 1);
        @(negedge clk); rd_valid = 0; rd_data = 8'h00; just = 1;
      end else begin
        just = 0;
        @(negedge clk);
      end
    end
    chk(got, req, "completion seen", int'(got), 1);
    chk(gotpass == epass, req, "outcome pass", int'(gotpass), int'(epass));
    chk(reads == en, req, "status reads", reads, en);
    chk(!reqbad, "R7", "request while read outstanding", int'(reqbad), 0);
    @(negedge clk);
    chk(!done_pass && !done_fail && !busy, "R7", "single-cycle done then idle",
        int'({done_pass, done_fail, busy}), 0);
  endtask

  task automatic fill(input logic [7:0] v);
    for (int i = 0; i < 16; i++) resp[i] = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && !rd_req && !done_pass && !done_fail, "R10", "outputs in reset",
        int'({busy, rd_req, done_pass, done_fail}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !rd_req, "R10", "idle after reset", int'({busy, rd_req}), 0);

    fill(8'h80); run("R1", 0, 8'h80, 1, 0);
    fill(8'h00); run("R1", 0, 8'h00, 3, 0);
    fill(8'h80); resp[0] = 8'h00; resp[1] = 8'h00; run("R2", 0, 8'h80, 1, 0);
    fill(8'h20); resp[1] = 8'h80; run("R3", 0, 8'h80, 2, 0);
    fill(8'h20); run("R3", 0, 8'h80, 1, 0);
    fill(8'h40); run("R4", 1, 8'h00, 1, 0);
    fill(8'h40); resp[0] = 8'h00; run("R5", 1, 8'h00, 2, 0);
    fill(8'h00); resp[0] = 8'h20; resp[1] = 8'h40; run("R6", 1, 8'h00, 1, 0);
    fill(8'h00); resp[0] = 8'h20; resp[1] = 8'h40; resp[3] = 8'h40; run("R6", 1, 8'h00, 1, 0);
    fill(8'h00); run("R8", 0, 8'h80, 1, 0);
    for (int i = 0; i < 16; i++) resp[i] = (i % 2) ? 8'h40 : 8'h00;
    run("R8", 1, 8'h00, 1, 0);
    // R9: second start during a poll must not change method or expected byte
    fill(8'h80); resp[0] = 8'h00; run("R9", 0, 8'h80, 3, 1);

    // R9: stray response while idle
    @(negedge clk); rd_valid = 1; rd_data = 8'h80;
    @(negedge clk); rd_valid = 0;
    begin
      bit any = 0;
      for (int k = 0; k < 4; k++) begin
        if (busy || rd_req || done_pass || done_fail) any = 1;
        @(negedge clk);
      end
      chk(!any, "R9", "activity after stray response", int'(any), 0);
    end
    chk(excl_bad == 0, "R7", "per-cycle exclusivity violations", excl_bad, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule